// File: doc/BRIEF.md
# DRAM Refresh Scheduler

The block keeps a 512-row DRAM refreshed without help from the main access controller. An interval timer marks the point at which each refresh falls due. A backlog counter records the refreshes that are due and not yet done. While the backlog is non-zero the block requests the memory bus. Once the controller grants it, the block takes the strobes and runs one refresh cycle. The cycle is CAS-before-RAS by default: both column strobes fall first, then RAS. If the mode input selects RAS-only, the block pulses only RAS and places its own 9-bit row counter on the address pins.

The controller may postpone refreshes. The backlog absorbs them, and once it reaches eight the block raises an urgent flag that asks for top priority. The backlog saturates and never wraps. Every strobe phase is a parameter in clock cycles, derived from the clock period. The defaults meet the DRAM minimums for RAS low time, RAS precharge, cycle time, and CAS setup and hold around the RAS edge. The default interval is the 15.6 us average spacing, which covers 512 rows in 8 ms.

Top module: `dram_refresh_sched`

## Requirements
- R1: The backlog rises by one every INTERVAL_CYC clock cycles. The first rise comes INTERVAL_CYC cycles after reset is released.
- R2: req_o is high exactly when the backlog is non-zero. urgent_o is high exactly when the backlog is at least 8.
- R3: Each completed refresh lowers the backlog by one. The backlog holds at BACKLOG_MAX (default 15) and never wraps. It changes by at most one per cycle.
- R4: A refresh starts only in a cycle in which req_o and gnt_i are both high. drive_o is high throughout the refresh, and req_o stays high while drive_o is high.
- R5: In CAS-before-RAS mode (ras_only_i = 0), both column strobes are low for exactly CAS_SETUP_CYC cycles before RAS falls. They stay low for CAS_HOLD_CYC cycles counted from the first RAS-low cycle. addr_o is 0 during the refresh.
- R6: RAS stays low for exactly RAS_LOW_CYC cycles. It then stays high for RAS_PRE_CYC cycles before drive_o falls, and drive_o is low for at least one cycle between refreshes.
- R7: In RAS-only mode (ras_only_i = 1), both column strobes stay high, and addr_o holds the row counter, unchanged, for the whole RAS-low time.
- R8: The row counter advances by one after each completed RAS-only refresh and wraps from 511 to 0. A CAS-before-RAS refresh leaves it unchanged. 512 consecutive RAS-only refreshes cover all 512 rows.
- R9: we_no is always high. While drive_o is low, ras_no, casl_no and cash_no are all high.
- R10: ras_only_i is sampled when a refresh starts. A change during the refresh does not alter that refresh.
- R11: Reset clears the backlog, the row counter and the timer. During reset all strobes are high, and req_o, urgent_o and drive_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| gnt_i | input | 1 | Bus grant from the access controller |
| req_o | output | 1 | Refresh request |
| urgent_o | output | 1 | Backlog at or above the urgent level |
| backlog_o | output | 4 | Pending refresh count |
| drive_o | output | 1 | Block owns the strobes and address |
| ras_no | output | 1 | Row strobe, active low |
| casl_no | output | 1 | Lower column strobe, active low |
| cash_no | output | 1 | Upper column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | 9 | Row address during RAS-only refresh |

## Verification
The checks assume that the controller keeps gnt_i high for as long as req_o stays high after a grant, so a refresh is never cut short. The bench's grant model follows req_o one half-cycle later and is withdrawn only while the block is idle. The ras_only_i input is changed only between refreshes, except in the test for R10. Reset is applied only while no refresh is running.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    RF_IDLE   = 2'd0,
    RF_CAS_SU = 2'd1,
    RF_RAS_LO = 2'd2,
    RF_PRE    = 2'd3
  } rf_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rf_backlog.sv
module rf_backlog #(
  parameter int BACKLOG_MAX = 15,
  parameter int URGENT_LVL  = 8,
  localparam int BW = $clog2(BACKLOG_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [BW-1:0] cnt_o,
  output logic          pend_o,
  output logic          urgent_o
);
  localparam logic [BW-1:0] CMAX = BW'(BACKLOG_MAX);
  localparam logic [BW-1:0] CURG = BW'(URGENT_LVL);

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i && cnt_q != CMAX)      cnt_d = cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign pend_o   = (cnt_q != '0);
  assign urgent_o = (cnt_q >= CURG);
endmodule

// File: rtl/rf_row_counter.sv
module rf_row_counter #(
  parameter int ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  // natural wrap at 2**ROW_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/rf_strobe_seq.sv
module rf_strobe_seq
  import dram_refresh_pkg::*;
#(
  parameter int CAS_SETUP_CYC = 3,
  parameter int CAS_HOLD_CYC  = 3,
  parameter int RAS_LOW_CYC   = 9,
  parameter int RAS_PRE_CYC   = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ras_only_i,
  output logic busy_o,
  output logic mode_o,
  output logic done_o,
  output logic ras_no,
  output logic cas_no
);
  localparam int LEN_MAX = max_int(max_int(CAS_SETUP_CYC, RAS_LOW_CYC), RAS_PRE_CYC);
  localparam int CW      = $clog2(LEN_MAX + 1);
  localparam logic [CW-1:0] SU_LAST  = CW'(CAS_SETUP_CYC - 1);
  localparam logic [CW-1:0] LO_LAST  = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(RAS_PRE_CYC - 1);
  localparam logic [CW-1:0] HOLD_N   = CW'(CAS_HOLD_CYC);

  rf_state_e     st_q, st_d;
  logic [CW-1:0] el_q, el_d;
  logic          mode_q, mode_d;

  always_comb begin
    st_d   = st_q;
    el_d   = el_q + 1'b1;
    mode_d = mode_q;
    unique case (st_q)
      RF_IDLE: begin
        el_d = '0;
        if (start_i) begin
          mode_d = ras_only_i;
          st_d   = ras_only_i ? RF_RAS_LO : RF_CAS_SU;
        end
      end
      RF_CAS_SU: if (el_q == SU_LAST) begin
        st_d = RF_RAS_LO;
        el_d = '0;
      end
      RF_RAS_LO: if (el_q == LO_LAST) begin
        st_d = RF_PRE;
        el_d = '0;
      end
      RF_PRE: if (el_q == PRE_LAST) begin
        st_d = RF_IDLE;
        el_d = '0;
      end
      default: begin
        st_d = RF_IDLE;
        el_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RF_IDLE;
      el_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      el_q   <= el_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o = (st_q != RF_IDLE);
  assign mode_o = mode_q;
  assign done_o = (st_q == RF_PRE) && (el_q == PRE_LAST);
  assign ras_no = (st_q != RF_RAS_LO);
  assign cas_no = !((st_q == RF_CAS_SU) ||
                    ((st_q == RF_RAS_LO) && !mode_q && (el_q < HOLD_N)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int INTERVAL_CYC  = 15600 / CLK_PERIOD_NS,
  parameter int ROW_W         = 9,
  parameter int BACKLOG_MAX   = 15,
  parameter int URGENT_LVL    = 8,
  parameter int CAS_SETUP_CYC = ceil_div(10, CLK_PERIOD_NS),
  parameter int CAS_HOLD_CYC  = ceil_div(10, CLK_PERIOD_NS),
  parameter int RAS_LOW_CYC   = ceil_div(35, CLK_PERIOD_NS),
  parameter int RAS_PRE_CYC   = max_int(ceil_div(25, CLK_PERIOD_NS),
                                        ceil_div(65, CLK_PERIOD_NS) - RAS_LOW_CYC - 1),
  localparam int BW = $clog2(BACKLOG_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             urgent_o,
  output logic [BW-1:0]    backlog_o,
  output logic             drive_o,
  output logic             ras_no,
  output logic             casl_no,
  output logic             cash_no,
  output logic             we_no,
  output logic [ROW_W-1:0] addr_o
);
  logic             tick, done, busy, mode, cas_n, pend;
  logic [ROW_W-1:0] row;

  rf_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  rf_backlog #(.BACKLOG_MAX(BACKLOG_MAX), .URGENT_LVL(URGENT_LVL)) u_backlog (
    .clk_i, .rst_ni, .inc_i(tick), .dec_i(done),
    .cnt_o(backlog_o), .pend_o(pend), .urgent_o(urgent_o)
  );

  rf_strobe_seq #(
    .CAS_SETUP_CYC(CAS_SETUP_CYC), .CAS_HOLD_CYC(CAS_HOLD_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(pend && gnt_i), .ras_only_i,
    .busy_o(busy), .mode_o(mode), .done_o(done), .ras_no(ras_no), .cas_no(cas_n)
  );

  rf_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk_i, .rst_ni, .adv_i(done && mode), .row_o(row)
  );

  assign req_o   = pend;
  assign drive_o = busy;
  assign casl_no = cas_n;
  assign cash_no = cas_n;
  assign we_no   = 1'b1;
  assign addr_o  = (busy && mode) ? row : '0;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int BW            = 4,
  parameter int ROW_W         = 9,
  parameter int BACKLOG_MAX   = 15,
  parameter int RAS_LOW_CYC   = 9,
  parameter int RAS_PRE_CYC   = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_o,
  input logic             urgent_o,
  input logic [BW-1:0]    backlog_o,
  input logic             drive_o,
  input logic             ras_no,
  input logic             casl_no,
  input logic             cash_no,
  input logic [ROW_W-1:0] addr_o
);
  localparam int LW = $clog2(RAS_LOW_CYC + 2) + 1;
  localparam int HW = $clog2(RAS_PRE_CYC + 2) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};
  localparam logic [BW-1:0] BMAX = BW'(BACKLOG_MAX);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      hi_cnt  <= HMAX;
    end else begin
      low_cnt <= ras_no ? '0 : low_cnt + 1'b1;
      hi_cnt  <= !ras_no ? '0 : ((hi_cnt == HMAX) ? HMAX : hi_cnt + 1'b1);
    end
  end

  assert_cas_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && !casl_no) |-> $past(!casl_no && !cash_no));
  assert_cas_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(casl_no) |-> ras_no);
  assert_ras_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> (low_cnt == LW'(RAS_LOW_CYC)));
  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (hi_cnt >= HW'(RAS_PRE_CYC + 1)));
  assert_busy_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> req_o);
  assert_idle_strobes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (ras_no && casl_no && cash_no));
  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no && $past(!ras_no)) |-> $stable(addr_o));
  assert_backlog_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backlog_o == $past(backlog_o)) || (backlog_o == $past(backlog_o) + 1'b1) ||
    (backlog_o == $past(backlog_o) - 1'b1));
  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(backlog_o) == BMAX) |-> (backlog_o >= BMAX - 1'b1));
  assert_urgent_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> req_o);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .BW(BW), .ROW_W(ROW_W), .BACKLOG_MAX(BACKLOG_MAX),
  .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .urgent_o(urgent_o),
  .backlog_o(backlog_o), .drive_o(drive_o), .ras_no(ras_no),
  .casl_no(casl_no), .cash_no(cash_no), .addr_o(addr_o)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int IV        = 64;
  localparam int CAS_SU    = 3;
  localparam int CAS_HOLD  = 3;
  localparam int RAS_LO    = 9;
  localparam int RAS_PRE   = 7;
  localparam int WDOG      = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ras_only = 1'b0, gnt = 1'b0, gnt_en = 1'b0;
  logic       req, urgent, drive, ras_n, casl_n, cash_n, we_n;
  logic [3:0] backlog;
  logic [8:0] addr;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_refresh_sched #(.CLK_PERIOD_NS(4), .INTERVAL_CYC(IV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_only_i(ras_only), .gnt_i(gnt),
    .req_o(req), .urgent_o(urgent), .backlog_o(backlog), .drive_o(drive),
    .ras_no(ras_n), .casl_no(casl_n), .cash_no(cash_n), .we_no(we_n), .addr_o(addr)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // controller model: grant follows request half a cycle later
  always @(negedge clk) gnt <= gnt_en && req;

  // strobe monitor
  logic       exp_mode = 1'b0;
  int         exp_row = 0;
  logic [511:0] seen = '0;
  int         last_fall_addr = -1;
  logic       ras_prev = 1, drv_prev = 0;
  int         cas_run = 0, low_run = 0, hi_run = 0, cas_in_low = 0;
  int         cur_addr = 0;
  bit         we_bad = 0, idle_bad = 0, nogrant_bad = 0, addr_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ras_prev = 1; drv_prev = 0; cas_run = 0; low_run = 0; hi_run = 0; cas_in_low = 0;
    end else if (!finished) begin
      if (!we_n) we_bad = 1;
      if (!drive && (!ras_n || !casl_n || !cash_n)) idle_bad = 1;
      if (drive && !drv_prev && !gnt) nogrant_bad = 1;
      if (ras_prev && !ras_n) begin
        last_fall_addr = addr;
        if (!exp_mode) begin
          chk("R5 cas setup cycles", cas_run, CAS_SU);
          chk("R5 cbr addr", addr, 0);
          cas_in_low = (!casl_n && !cash_n) ? 1 : 0;
        end else begin
          chk("R7 cas high", {casl_n, cash_n}, 3);
          chk("R8 row addr", addr, exp_row);
          seen[addr] = 1'b1;
          cur_addr = addr;
          exp_row = (exp_row + 1) % 512;
        end
      end else if (!ras_n) begin
        if (!casl_n && !cash_n) cas_in_low++;
        if (exp_mode && (addr != cur_addr[8:0] || !casl_n || !cash_n)) addr_bad = 1;
      end
      if (!ras_prev && ras_n) begin
        chk("R6 ras low cycles", low_run, RAS_LO);
        if (!exp_mode) chk("R5 cas hold cycles", cas_in_low, CAS_HOLD);
      end
      if (drv_prev && !drive) chk("R6 precharge cycles", hi_run, RAS_PRE);
      cas_run = (!casl_n && !cash_n) ? cas_run + 1 : 0;
      low_run = !ras_n ? low_run + 1 : 0;
      hi_run  = ras_n ? hi_run + 1 : 0;
      ras_prev = ras_n;
      drv_prev = drive;
    end
  end

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      summary();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {ras_only, gnt_en, intervals, exp_backlog, exp_urgent}
  typedef struct packed {
    logic       ro;
    logic       ge;
    logic [7:0] n;
    logic [3:0] bl;
    logic       urg;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 8'd3,  4'd3,  1'b0},   // R1
    '{1'b0, 1'b0, 8'd4,  4'd7,  1'b0},   // R2 below urgent
    '{1'b0, 1'b0, 8'd1,  4'd8,  1'b1},   // R2 urgent level
    '{1'b0, 1'b0, 8'd10, 4'd15, 1'b1},   // R3 saturation
    '{1'b0, 1'b1, 8'd10, 4'd0,  1'b0},   // R3 drain with CBR
    '{1'b1, 1'b1, 8'd4,  4'd0,  1'b0},   // R7 RAS-only
    '{1'b0, 1'b1, 8'd2,  4'd0,  1'b0},   // R8 CBR keeps row
    '{1'b1, 1'b0, 8'd2,  4'd2,  1'b0},   // R4 no grant
    '{1'b1, 1'b1, 8'd3,  4'd0,  1'b0}    // R8 resume rows
  };

  initial begin
    // R11 reset state
    wait_cyc(3);
    chk("R11 ras_n in reset", ras_n, 1);
    chk("R11 cas in reset", {casl_n, cash_n}, 3);
    chk("R11 req/urgent/drive in reset", {req, urgent, drive}, 0);
    chk("R11 backlog in reset", backlog, 0);
    rst_n = 1'b1;
    wait_cyc(IV / 2);
    for (int i = 0; i < 9; i++) begin
      ras_only = VECS[i].ro;
      exp_mode = VECS[i].ro;
      gnt_en   = VECS[i].ge;
      wait_cyc(IV * VECS[i].n);
      chk($sformatf("R1 R3 backlog vec %0d", i), backlog, VECS[i].bl);
      chk($sformatf("R2 req vec %0d", i), req, VECS[i].bl != 0);
      chk($sformatf("R2 urgent vec %0d", i), urgent, VECS[i].urg);
    end

    // R10: mode flips during a RAS-only refresh
    gnt_en = 1'b0;
    ras_only = 1'b1; exp_mode = 1'b1;
    wait_cyc(IV);
    gnt_en = 1'b1;
    while (!drive) @(negedge clk);
    ras_only = 1'b0;
    while (drive) @(negedge clk);
    exp_mode = 1'b0;
    chk("R10 row used", last_fall_addr, (exp_row + 511) % 512);
    wait_cyc(IV / 2);
    realign();

    // R8: 512-interval window in RAS-only mode covers every row
    ras_only = 1'b1; exp_mode = 1'b1;
    seen = '0;
    wait_cyc(IV * 512);
    chk("R8 rows covered", $countones(seen), 512);
    chk("R8 backlog after window", backlog, 0);

    // R11: reset mid-run clears row and backlog
    gnt_en = 1'b0;
    wait_cyc(IV * 2);
    chk("R4 idle without grant", drive, 0);
    chk("R11 backlog before reset", backlog, 2);
    rst_n = 1'b0;
    wait_cyc(2);
    chk("R11 backlog cleared", backlog, 0);
    chk("R11 req cleared", req, 0);
    exp_row = 0;
    rst_n = 1'b1;
    gnt_en = 1'b1;
    wait_cyc(IV + IV / 2);
    chk("R11 row restarts at 0", last_fall_addr, 0);
    chk("R1 backlog after restart", backlog, 0);

    chk("R9 we high", we_bad, 0);
    chk("R9 idle strobes high", idle_bad, 0);
    chk("R4 start only with grant", nogrant_bad, 0);
    chk("R7 addr stable cas high", addr_bad, 0);
    summary();
  end

  // re-synchronise to mid-interval after an asynchronous stretch
  task automatic realign();
    int k;
    k = 0;
    while (backlog == 0 && k < IV) begin
      @(negedge clk);
      k++;
    end
    while (drive || req) @(negedge clk);
    wait_cyc(IV / 4);
  endtask
endmodule